// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Select

This block keeps the wiper setting of a 256-step digital potentiometer in an 8-bit volatile register. It turns that setting into a one-hot enable vector for the 256 switches along the resistor string. Tap 0 is the low end of the string and tap 255 is the high end.

The register has four ways to change:

- The power-up preload copies bank-0 register 0.
- A parallel transfer copies any of the four bank-0 data registers.
- A host write loads a byte taken from the serial interface.
- A step pulse moves the value up or down by one position.

All loads are synchronous to `clk`. The step strobe is the gated serial clock, already turned into a one-cycle pulse in the `clk` domain. The nonvolatile registers stay outside this block. Their bank-0 contents come in as a flat bus, and the bank code of each transfer request is checked here.

Top module: `wcr_wiper_core`

## Requirements
- R1: While `por_n` is low, each rising clock edge loads the register with bank-0 register 0, which is `bank0_regs[7:0]`. After `por_n` rises, the register holds that value until another source acts.
- R2: A host write (`host_wr_stb` = 1) loads `host_wr_data` at the next edge.
- R3: A transfer with `xfer_bank` = 2'b00 loads bank-0 register `xfer_sel` at the next edge. Register k sits at `bank0_regs[8k+7:8k]`.
- R4: A transfer with `xfer_bank` equal to 1, 2 or 3 is rejected. It does not change the register.
- R5: A step pulse (`step_stb` = 1) adds one when `step_up` = 1 and subtracts one when `step_up` = 0.
- R6: A step up from 8'hFF leaves 8'hFF, and a step down from 8'h00 leaves 8'h00. Neither wraps.
- R7: When sources coincide, the winner follows this order: power-up, then an accepted transfer, then host write, then step. A rejected transfer takes no part in this order.
- R8: `tap_en` always has exactly one bit set, and its index equals `wiper_pos`.
- R9: Position 8'h00 enables `tap_en[0]` (low terminal), and 8'hFF enables `tap_en[255]` (high terminal).
- R10: With no strobe asserted, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-up reset, active low, forces the preload |
| host_wr_stb | input | 1 | Host write strobe |
| host_wr_data | input | 8 | Host write value |
| xfer_stb | input | 1 | Data-register-to-wiper transfer strobe |
| xfer_bank | input | 2 | Bank code of the transfer request |
| xfer_sel | input | 2 | Register index within the bank |
| bank0_regs | input | 32 | Bank-0 data registers, register k at bits 8k+7:8k |
| step_stb | input | 1 | Single-step pulse from the gated serial clock |
| step_up | input | 1 | Step direction, 1 = toward the high terminal |
| wiper_pos | output | 8 | Current wiper position |
| tap_en | output | 256 | One-hot switch enables |

## Verification
The first patterns load each source on its own. They are a host byte, transfers from three bank-0 registers holding distinct values, and steps in both directions. These show that each source reaches the register and that the selected word comes from the right slice of the bus. Transfers naming banks 1 to 3 come next, issued alone and again alongside a host write. They separate "rejected and silent" from "rejected but blocking lower sources". Steps at 8'h00 and 8'hFF separate saturation from wrap-around. Coincident strobes and a host write during power-up confirm the priority order. A sweep of host values in strides of 17 checks that the one-hot decode maps every high and low nibble to the right tap.

// File: rtl/wcr_pkg.sv
package wcr_pkg;

  // Which source updated the wiper register in the current cycle.
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_POR  = 3'd1,
    SRC_XFER = 3'd2,
    SRC_HOST = 3'd3,
    SRC_STEP = 3'd4
  } wcr_src_e;

endpackage

// File: rtl/wcr_step_unit.sv
module wcr_step_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur_pos,
  input  logic         dir_up,
  output logic [W-1:0] stepped_pos,
  output logic         at_rail
);

  localparam logic [W-1:0] TOP_POS = {W{1'b1}};
  localparam logic [W-1:0] BOT_POS = '0;

  // Saturating one-position move.
  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v, input logic up);
    logic [W-1:0] r;
    if (up) r = (v == TOP_POS) ? v : v + 1'b1;
    else    r = (v == BOT_POS) ? v : v - 1'b1;
    return r;
  endfunction

  // True when a move in the given direction would leave the range.
  function automatic logic rail_hit(input logic [W-1:0] v, input logic up);
    return up ? (v == TOP_POS) : (v == BOT_POS);
  endfunction

  always_comb begin
    stepped_pos = sat_step(cur_pos, dir_up);
    at_rail     = rail_hit(cur_pos, dir_up);
  end

endmodule

// File: rtl/wcr_load_arbiter.sv
module wcr_load_arbiter
  import wcr_pkg::*;
#(
  parameter int W      = 8,
  parameter int NREG   = 4,
  parameter int BANK_W = 2,
  parameter int SEL_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              por_n,
  input  logic              host_wr_stb,
  input  logic [W-1:0]      host_wr_data,
  input  logic              xfer_stb,
  input  logic [BANK_W-1:0] xfer_bank,
  input  logic [SEL_W-1:0]  xfer_sel,
  input  logic [NREG*W-1:0] bank0_regs,
  input  logic              step_stb,
  input  logic [W-1:0]      stepped_pos,
  output logic [W-1:0]      next_pos,
  output logic              load_en,
  output logic              xfer_ok,
  output wcr_src_e          src
);

  localparam logic [BANK_W-1:0] HOME_BANK = '0;

  // Unpack the bank-0 words so they can be indexed.
  logic [W-1:0] bank_word [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_unpack
      assign bank_word[g] = bank0_regs[g*W +: W];
    end
  endgenerate

  // Only the home bank may feed the wiper register.
  function automatic logic bank_allowed(input logic [BANK_W-1:0] b);
    return b == HOME_BANK;
  endfunction

  // Fixed-priority pick among the active sources.
  function automatic wcr_src_e pick_source(input logic por_act, input logic xfer_act,
                                           input logic host_act, input logic step_act);
    wcr_src_e s;
    if      (por_act)  s = SRC_POR;
    else if (xfer_act) s = SRC_XFER;
    else if (host_act) s = SRC_HOST;
    else if (step_act) s = SRC_STEP;
    else               s = SRC_NONE;
    return s;
  endfunction

  always_comb begin
    xfer_ok = xfer_stb && bank_allowed(xfer_bank);
    src     = pick_source(!por_n, xfer_ok, host_wr_stb, step_stb);
    case (src)
      SRC_POR:  next_pos = bank_word[0];
      SRC_XFER: next_pos = bank_word[xfer_sel];
      SRC_HOST: next_pos = host_wr_data;
      SRC_STEP: next_pos = stepped_pos;
      default:  next_pos = stepped_pos;
    endcase
    load_en = (src != SRC_NONE);
  end

endmodule

// File: rtl/wcr_tap_decoder.sv
module wcr_tap_decoder #(
  parameter int W = 8
) (
  input  logic [W-1:0]        pos,
  output logic [(1<<W)-1:0]   taps
);

  localparam int LO_W = W / 2;
  localparam int HI_W = W - LO_W;
  localparam int LO_N = 1 << LO_W;
  localparam int HI_N = 1 << HI_W;

  // Plain binary-to-one-hot decoders for each half of the position.
  function automatic logic [LO_N-1:0] dec_lo(input logic [LO_W-1:0] v);
    logic [LO_N-1:0] r;
    for (int i = 0; i < LO_N; i++) r[i] = (v == LO_W'(i));
    return r;
  endfunction

  function automatic logic [HI_N-1:0] dec_hi(input logic [HI_W-1:0] v);
    logic [HI_N-1:0] r;
    for (int i = 0; i < HI_N; i++) r[i] = (v == HI_W'(i));
    return r;
  endfunction

  logic [LO_N-1:0] lo_oh;
  logic [HI_N-1:0] hi_oh;

  always_comb begin
    lo_oh = dec_lo(pos[LO_W-1:0]);
    hi_oh = dec_hi(pos[W-1:LO_W]);
  end

  // Second stage: one AND gate per tap switch.
  genvar h, l;
  generate
    for (h = 0; h < HI_N; h++) begin : g_row
      for (l = 0; l < LO_N; l++) begin : g_col
        assign taps[h*LO_N + l] = hi_oh[h] & lo_oh[l];
      end
    end
  endgenerate

endmodule

// File: rtl/wcr_wiper_core.sv
module wcr_wiper_core
  import wcr_pkg::*;
#(
  parameter int W      = 8,
  parameter int NREG   = 4,
  parameter int BANK_W = 2
) (
  input  logic                              clk,
  input  logic                              por_n,
  input  logic                              host_wr_stb,
  input  logic [W-1:0]                      host_wr_data,
  input  logic                              xfer_stb,
  input  logic [BANK_W-1:0]                 xfer_bank,
  input  logic [((NREG>1)?$clog2(NREG):1)-1:0] xfer_sel,
  input  logic [NREG*W-1:0]                 bank0_regs,
  input  logic                              step_stb,
  input  logic                              step_up,
  output logic [W-1:0]                      wiper_pos,
  output logic [(1<<W)-1:0]                 tap_en
);

  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  // Internal events brought out as named wires for the checker.
  logic [W-1:0] stepped_pos;
  logic         step_at_rail;
  logic [W-1:0] next_pos;
  logic         load_en;
  logic         xfer_ok;
  wcr_src_e     src;
  logic [W-1:0] pos_q;

  wcr_step_unit #(.W(W)) step_i (
    .cur_pos     (pos_q),
    .dir_up      (step_up),
    .stepped_pos (stepped_pos),
    .at_rail     (step_at_rail)
  );

  wcr_load_arbiter #(.W(W), .NREG(NREG), .BANK_W(BANK_W), .SEL_W(SEL_W)) arb_i (
    .por_n        (por_n),
    .host_wr_stb  (host_wr_stb),
    .host_wr_data (host_wr_data),
    .xfer_stb     (xfer_stb),
    .xfer_bank    (xfer_bank),
    .xfer_sel     (xfer_sel),
    .bank0_regs   (bank0_regs),
    .step_stb     (step_stb),
    .stepped_pos  (stepped_pos),
    .next_pos     (next_pos),
    .load_en      (load_en),
    .xfer_ok      (xfer_ok),
    .src          (src)
  );

  // The volatile wiper register itself; the power-up preload acts as its reset.
  always_ff @(posedge clk) begin
    if (load_en) pos_q <= next_pos;
  end

  assign wiper_pos = pos_q;

  wcr_tap_decoder #(.W(W)) dec_i (
    .pos  (pos_q),
    .taps (tap_en)
  );

endmodule

// File: rtl/wcr_wiper_chk.sv
module wcr_wiper_chk
  import wcr_pkg::*;
#(
  parameter int W      = 8,
  parameter int NREG   = 4,
  parameter int BANK_W = 2,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              host_wr_stb,
  input  logic [W-1:0]      host_wr_data,
  input  logic              xfer_stb,
  input  logic [BANK_W-1:0] xfer_bank,
  input  logic [SEL_W-1:0]  xfer_sel,
  input  logic [NREG*W-1:0] bank0_regs,
  input  logic              step_stb,
  input  logic              step_up,
  input  logic [W-1:0]      wiper_pos,
  input  logic [(1<<W)-1:0] tap_en,
  input  logic              xfer_ok,
  input  wcr_src_e          src,
  input  logic              step_at_rail
);

  localparam logic [W-1:0] TOP_POS = {W{1'b1}};

  logic [W-1:0] sel_word;
  logic         home_req;
  assign sel_word = bank0_regs[xfer_sel*W +: W];
  assign home_req = xfer_stb && (xfer_bank == '0);

  AST_POR_PRELOAD: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_n) |-> wiper_pos == $past(bank0_regs[W-1:0])); // R1

  AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!por_n)
    (host_wr_stb && !home_req) |=> wiper_pos == $past(host_wr_data)); // R2

  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!por_n)
    home_req |=> wiper_pos == $past(sel_word)); // R3

  AST_BANK_GUARD: assert property (@(posedge clk) disable iff (!por_n)
    (xfer_stb && xfer_bank != '0) |-> !xfer_ok); // R4

  AST_STEP_MOVE: assert property (@(posedge clk) disable iff (!por_n)
    (step_stb && step_up && !host_wr_stb && !home_req && wiper_pos != TOP_POS)
      |=> wiper_pos == W'($past(wiper_pos) + 1'b1)); // R5

  AST_STEP_SAT_HI: assert property (@(posedge clk) disable iff (!por_n)
    (step_stb && step_up && !host_wr_stb && !home_req && wiper_pos == TOP_POS)
      |=> wiper_pos == TOP_POS); // R6

  AST_STEP_SAT_LO: assert property (@(posedge clk) disable iff (!por_n)
    (step_stb && !step_up && !host_wr_stb && !home_req && wiper_pos == '0)
      |=> wiper_pos == '0); // R6

  AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!por_n)
    (home_req && (host_wr_stb || step_stb)) |-> src == SRC_XFER); // R7

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!por_n)
    $countones(tap_en) == 1); // R8

  AST_TAP_INDEX: assert property (@(posedge clk) disable iff (!por_n)
    tap_en[wiper_pos]); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!host_wr_stb && !xfer_stb && !step_stb) |=> $stable(wiper_pos)); // R10

  AST_RAIL_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    (step_at_rail && step_stb && src == SRC_STEP) |=> $stable(wiper_pos)); // R6

endmodule

bind wcr_wiper_core wcr_wiper_chk #(.W(W), .NREG(NREG), .BANK_W(BANK_W), .SEL_W(SEL_W)) chk_i (
  .clk          (clk),
  .por_n        (por_n),
  .host_wr_stb  (host_wr_stb),
  .host_wr_data (host_wr_data),
  .xfer_stb     (xfer_stb),
  .xfer_bank    (xfer_bank),
  .xfer_sel     (xfer_sel),
  .bank0_regs   (bank0_regs),
  .step_stb     (step_stb),
  .step_up      (step_up),
  .wiper_pos    (wiper_pos),
  .tap_en       (tap_en),
  .xfer_ok      (xfer_ok),
  .src          (src),
  .step_at_rail (step_at_rail)
);

// File: tb/wcr_wiper_core_tb.sv
module wcr_wiper_core_tb_top;

  logic         clk = 1'b0;
  logic         por_n = 1'b0;
  logic         host_wr_stb = 1'b0;
  logic [7:0]   host_wr_data = '0;
  logic         xfer_stb = 1'b0;
  logic [1:0]   xfer_bank = '0;
  logic [1:0]   xfer_sel = '0;
  logic [31:0]  bank0_regs = {8'hFE, 8'h01, 8'h5A, 8'h3C};
  logic         step_stb = 1'b0;
  logic         step_up = 1'b0;
  logic [7:0]   wiper_pos;
  logic [255:0] tap_en;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] model_pos = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  wcr_wiper_core dut_i (
    .clk          (clk),
    .por_n        (por_n),
    .host_wr_stb  (host_wr_stb),
    .host_wr_data (host_wr_data),
    .xfer_stb     (xfer_stb),
    .xfer_bank    (xfer_bank),
    .xfer_sel     (xfer_sel),
    .bank0_regs   (bank0_regs),
    .step_stb     (step_stb),
    .step_up      (step_up),
    .wiper_pos    (wiper_pos),
    .tap_en       (tap_en)
  );

  // Independent statement of the load rules.
  function automatic logic [7:0] rule_next(input logic [7:0] cur, input logic p, input logic xs,
                                           input logic [1:0] xb, input logic [1:0] xsel,
                                           input logic hs, input logic [7:0] hd,
                                           input logic ss, input logic su, input logic [31:0] regs);
    if (!p)                    return regs[7:0];
    if (xs && xb == 2'd0)      return regs >> (8 * xsel);
    if (hs)                    return hd;
    if (ss && su)              return (cur == 8'd255) ? cur : cur + 8'd1;
    if (ss && !su)             return (cur == 8'd0) ? cur : cur - 8'd1;
    return cur;
  endfunction

  // Driver: apply one cycle of stimulus and queue the expected outcome.
  task automatic drive(input logic p, input logic xs, input logic [1:0] xb, input logic [1:0] xsel,
                       input logic hs, input logic [7:0] hd, input logic ss, input logic su,
                       input string tag);
    @(negedge clk);
    por_n = p; xfer_stb = xs; xfer_bank = xb; xfer_sel = xsel;
    host_wr_stb = hs; host_wr_data = hd; step_stb = ss; step_up = su;
    model_pos = rule_next(model_pos, p, xs, xb, xsel, hs, hd, ss, su, bank0_regs);
    exp_q.push_back(model_pos);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask
  task automatic host(input logic [7:0] v, input string tag);
    drive(1'b1, 1'b0, 2'd0, 2'd0, 1'b1, v, 1'b0, 1'b0, tag);
  endtask
  task automatic xfer(input logic [1:0] b, input logic [1:0] s, input string tag);
    drive(1'b1, 1'b1, b, s, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask
  task automatic step(input logic up, input string tag);
    drive(1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b1, up, tag);
  endtask

  // Monitor: after each edge, compare against the oldest queued item.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [7:0]   e;
      logic [255:0] et;
      string        t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      et = '0;
      et[e] = 1'b1;
      n_checks++;
      if (wiper_pos !== e) begin
        n_fail++;
        $display("FAIL %s wiper_pos actual=%02h expected=%02h", t, wiper_pos, e);
      end
      n_checks++;
      if (tap_en !== et) begin
        n_fail++;
        $display("FAIL %s/R8 tap_en actual=%064h expected=%064h", t, tap_en, et);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: power-up preload from bank-0 register 0
    drive(1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R1");
    drive(1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 8'h00, 1'b0, 1'b0, "R1");
    idle("R10");
    idle("R10");
    // R2: host write
    host(8'hA5, "R2");
    idle("R10");
    // R3: transfers from the home bank
    xfer(2'd0, 2'd1, "R3");
    xfer(2'd0, 2'd3, "R3");
    xfer(2'd0, 2'd2, "R3");
    // R4: other banks are rejected
    xfer(2'd1, 2'd1, "R4");
    xfer(2'd2, 2'd3, "R4");
    xfer(2'd3, 2'd0, "R4");
    // R5 and R6: steps and the low rail
    step(1'b1, "R5");
    step(1'b0, "R5");
    step(1'b0, "R5");
    step(1'b0, "R6");
    idle("R9");
    // R6 high rail
    host(8'hFE, "R2");
    step(1'b1, "R5");
    step(1'b1, "R6");
    step(1'b1, "R6");
    idle("R9");
    // R7: coincident sources
    drive(1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 8'h77, 1'b1, 1'b0, "R7");
    drive(1'b1, 1'b0, 2'd0, 2'd0, 1'b1, 8'h77, 1'b1, 1'b1, "R7");
    drive(1'b1, 1'b1, 2'd1, 2'd2, 1'b1, 8'h12, 1'b0, 1'b0, "R7");
    drive(1'b1, 1'b1, 2'd2, 2'd1, 1'b0, 8'h00, 1'b1, 1'b1, "R7");
    drive(1'b0, 1'b1, 2'd0, 2'd3, 1'b1, 8'h99, 1'b1, 1'b1, "R7");
    idle("R1");
    // R8: decode sweep
    for (int v = 0; v < 256; v += 17) host(8'(v), "R8");
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule